// File: doc/BRIEF.md
# Pipelined Segmented-Match Ternary CAM

This block is a ternary content-addressable memory. Each stored entry holds a 144-bit value and a don't-care mask of the same width. An incoming search key is compared across five pipeline stages. The first stage covers the top 8 bits of the word, and each of the next four stages covers a 34-bit field below it, moving from the most significant end towards bit 0. An entry takes part in a stage only if it matched every earlier segment. Once an entry fails a segment, it is not compared again for that key.

The entries are split into groups of eight. These are the local groups of the search lines. In each stage, the current segment of the key reaches a group only when that group still holds at least one surviving entry. Every other group receives zeros. The pipeline accepts a new key on every cycle. Five cycles after a key is captured, the block reports a result strobe, a hit flag, the index of the lowest-numbered matching entry, and two activity counts for each stage. The first count is the number of entries compared in that stage. The second is the number of groups that received search data.

Software loads entries through a single write port that takes an index, a value and a mask. A write also marks its entry as occupied. After reset no entry is occupied, so nothing can match until it has been written.

Top module: `segTcam`

## Requirements
- R1: A stored bit whose don't-care mask bit is 1 matches either key value. A stored bit whose mask bit is 0 matches only an equal key bit. An entry matches a key when every bit of all 144 matches.
- R2: When `wrEn` is high at a rising edge, entry `wrIdx` takes `wrValue` and `wrDontCare` and becomes occupied. A key captured on any later edge is compared against the new contents. An entry that has not been written since reset never matches.
- R3: A key is captured when `srchValid` is high at rising edge N. Its result appears right after edge N+5, with `resValid` high for exactly that one cycle. A new key may be captured on every edge, and `resValid` is low in every cycle that carries no result.
- R4: With `resValid` high, `matchValid` is 1 exactly when some occupied entry matches the key. `matchIdx` then gives the lowest index among the matching entries. `matchValid` is never high while `resValid` is low.
- R5: The stages compare the word in this order: stage 0 covers key bits [143:136], stage 1 bits [135:102], stage 2 bits [101:68], stage 3 bits [67:34], and stage 4 bits [33:0]. The field `actEntries[7k+6:7k]` counts the entries compared in stage k. For stage 0 this is the number of occupied entries. For a later stage it is the number of entries that matched every earlier segment.
- R6: Group g is made of entries 8g to 8g+7. The field `actGroups[4k+3:4k]` counts the groups that hold at least one entry compared in stage k. Only those groups receive the stage's key segment.
- R7: For a valid result, the entry count never rises from one stage to the next. In every stage the group count is no greater than the entry count, and the entry count is no greater than eight times the group count.
- R8: While `rstN` is low, `resValid` and `matchValid` are 0, and reset leaves every entry unoccupied.
- R9: Keys captured on consecutive edges each produce their own result, in issue order, with no interference between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one entry |
| wrIdx | input | 6 | Entry written |
| wrValue | input | 144 | Stored value |
| wrDontCare | input | 144 | Per-bit don't-care mask, 1 = wildcard |
| srchValid | input | 1 | Key present this cycle |
| srchKey | input | 144 | Search key |
| resValid | output | 1 | Result strobe for the key captured five edges earlier |
| matchValid | output | 1 | At least one entry matched |
| matchIdx | output | 6 | Lowest matching entry index |
| actEntries | output | 35 | Entries compared per stage, 7 bits per stage, stage 0 in the low bits |
| actGroups | output | 20 | Groups given search data per stage, 4 bits per stage, stage 0 in the low bits |

## Verification
On every cycle, the assertions check the following: the result strobe follows captured keys by the fixed latency, a hit is reported only together with a result strobe and a surviving last-stage entry, and the per-stage activity counts shrink and stay within the group-to-entry bounds. The bench's scenarios are the only way to show which entry wins and what the exact counts are. To do this it loads a set of entries whose prefixes are shared at different depths, plus several wildcard entries, and then sweeps keys against a single-cycle reference model: every stored word, single-bit corruptions in each segment, and partly random keys. It also covers rewriting an entry and the empty table after reset.

// File: rtl/segTcamPkg.sv
package segTcamPkg;
  // Upper bound on pipeline stages carried by the strobe bundle.
  localparam int CAM_MAX_STAGES = 16;

  typedef struct packed {
    logic                      wrFire;
    logic [CAM_MAX_STAGES-1:0] stageLoad;
    logic                      resLoad;
  } camStrobes_t;
endpackage

// File: rtl/segTcamPrioEnc.sv
module segTcamPrioEnc #(
  parameter int N = 64,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Lowest set bit wins; scan downward so the last hit is the smallest index.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/segTcamStage.sv
module segTcamStage #(
  parameter int ENTRIES    = 64,
  parameter int GROUP_SIZE = 8,
  parameter int WORD_W     = 144,
  parameter int NUM_SEGS   = 5,
  parameter int STAGE_IDX  = 0,
  parameter int SEG_LO     = 136,
  parameter int SEG_W      = 8,
  parameter int CNT_W      = 7,
  parameter int GCNT_W     = 4,
  localparam int GROUPS    = ENTRIES / GROUP_SIZE
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             load,
  input  logic [WORD_W-1:0]                inKey,
  input  logic [ENTRIES-1:0]               inSurv,
  input  logic [NUM_SEGS*CNT_W-1:0]        inCntE,
  input  logic [NUM_SEGS*GCNT_W-1:0]       inCntG,
  input  logic [ENTRIES-1:0][WORD_W-1:0]   memVal,
  input  logic [ENTRIES-1:0][WORD_W-1:0]   memDc,
  output logic [WORD_W-1:0]                fwdKey,
  output logic [ENTRIES-1:0]               fwdSurv,
  output logic [NUM_SEGS*CNT_W-1:0]        fwdCntE,
  output logic [NUM_SEGS*GCNT_W-1:0]       fwdCntG
);
  function automatic logic [WORD_W-1:0] buildMask();
    logic [WORD_W-1:0] m;
    for (int b = 0; b < WORD_W; b++) m[b] = (b >= SEG_LO) && (b < SEG_LO + SEG_W);
    return m;
  endfunction

  localparam logic [WORD_W-1:0] SEG_MASK = buildMask();

  logic [WORD_W-1:0]          keyQ;
  logic [ENTRIES-1:0]         survQ;
  logic [NUM_SEGS*CNT_W-1:0]  cntEQ;
  logic [NUM_SEGS*GCNT_W-1:0] cntGQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ  <= '0;
      survQ <= '0;
      cntEQ <= '0;
      cntGQ <= '0;
    end else if (load) begin
      keyQ  <= inKey;
      survQ <= inSurv;
      cntEQ <= inCntE;
      cntGQ <= inCntG;
    end
  end

  logic [GROUPS-1:0] grpLive;

  for (genvar g = 0; g < GROUPS; g++) begin : gGrp
    logic [WORD_W-1:0] localKey;
    assign grpLive[g] = |survQ[g*GROUP_SIZE +: GROUP_SIZE];
    // Local search lines of an idle group stay parked at zero.
    assign localKey = grpLive[g] ? (keyQ & SEG_MASK) : '0;
    for (genvar e = 0; e < GROUP_SIZE; e++) begin : gEnt
      localparam int IDX = g * GROUP_SIZE + e;
      assign fwdSurv[IDX] = survQ[IDX] &
                            ~|((memVal[IDX] ^ localKey) & ~memDc[IDX] & SEG_MASK);
    end
  end

  logic [CNT_W-1:0]  ownE;
  logic [GCNT_W-1:0] ownG;

  always_comb begin
    ownE = '0;
    for (int i = 0; i < ENTRIES; i++) ownE = ownE + CNT_W'(survQ[i]);
    ownG = '0;
    for (int i = 0; i < GROUPS; i++) ownG = ownG + GCNT_W'(grpLive[i]);
    fwdCntE = cntEQ;
    fwdCntE[STAGE_IDX*CNT_W +: CNT_W] = ownE;
    fwdCntG = cntGQ;
    fwdCntG[STAGE_IDX*GCNT_W +: GCNT_W] = ownG;
  end

  assign fwdKey = keyQ;
endmodule

// File: rtl/segTcamCtrl.sv
module segTcamCtrl import segTcamPkg::*; #(
  parameter int NUM_SEGS = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        srchValid,
  output camStrobes_t strb,
  output logic        resValid
);
  // vPipe[k] marks stage k holding a live key; vPipe[NUM_SEGS] marks the result.
  logic [NUM_SEGS:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[NUM_SEGS-1:0], srchValid};
  end

  always_comb begin
    strb              = '0;
    strb.wrFire       = wrEn;
    strb.stageLoad[0] = srchValid;
    for (int k = 1; k < NUM_SEGS; k++) strb.stageLoad[k] = vPipe[k-1];
    strb.resLoad      = vPipe[NUM_SEGS-1];
  end

  assign resValid = vPipe[NUM_SEGS];
endmodule

// File: rtl/segTcamDatapath.sv
module segTcamDatapath import segTcamPkg::*; #(
  parameter int ENTRIES    = 64,
  parameter int GROUP_SIZE = 8,
  parameter int SEG0_W     = 8,
  parameter int SEGN_W     = 34,
  parameter int NUM_SEGS   = 5,
  localparam int WORD_W    = SEG0_W + (NUM_SEGS - 1) * SEGN_W,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int GROUPS    = ENTRIES / GROUP_SIZE,
  localparam int CNT_W     = $clog2(ENTRIES + 1),
  localparam int GCNT_W    = $clog2(GROUPS + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  camStrobes_t                strb,
  input  logic [IDX_W-1:0]           wrIdx,
  input  logic [WORD_W-1:0]          wrValue,
  input  logic [WORD_W-1:0]          wrDontCare,
  input  logic [WORD_W-1:0]          srchKey,
  output logic                       resHit,
  output logic [IDX_W-1:0]           resIdx,
  output logic [NUM_SEGS*CNT_W-1:0]  resCntE,
  output logic [NUM_SEGS*GCNT_W-1:0] resCntG
);
  logic [ENTRIES-1:0][WORD_W-1:0] memVal;
  logic [ENTRIES-1:0][WORD_W-1:0] memDc;
  logic [ENTRIES-1:0]             entryOk;

  always_ff @(posedge clk) begin
    if (strb.wrFire) begin
      memVal[wrIdx] <= wrValue;
      memDc[wrIdx]  <= wrDontCare;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            entryOk        <= '0;
    else if (strb.wrFire) entryOk[wrIdx] <= 1'b1;
  end

  logic [WORD_W-1:0]          chKey  [NUM_SEGS+1];
  logic [ENTRIES-1:0]         chSurv [NUM_SEGS+1];
  logic [NUM_SEGS*CNT_W-1:0]  chCntE [NUM_SEGS+1];
  logic [NUM_SEGS*GCNT_W-1:0] chCntG [NUM_SEGS+1];

  assign chKey[0]  = srchKey;
  assign chSurv[0] = entryOk;
  assign chCntE[0] = '0;
  assign chCntG[0] = '0;

  for (genvar k = 0; k < NUM_SEGS; k++) begin : gStage
    segTcamStage #(
      .ENTRIES   (ENTRIES),
      .GROUP_SIZE(GROUP_SIZE),
      .WORD_W    (WORD_W),
      .NUM_SEGS  (NUM_SEGS),
      .STAGE_IDX (k),
      .SEG_LO    (WORD_W - SEG0_W - k * SEGN_W),
      .SEG_W     ((k == 0) ? SEG0_W : SEGN_W),
      .CNT_W     (CNT_W),
      .GCNT_W    (GCNT_W)
    ) uStage (
      .clk    (clk),
      .rstN   (rstN),
      .load   (strb.stageLoad[k]),
      .inKey  (chKey[k]),
      .inSurv (chSurv[k]),
      .inCntE (chCntE[k]),
      .inCntG (chCntG[k]),
      .memVal (memVal),
      .memDc  (memDc),
      .fwdKey (chKey[k+1]),
      .fwdSurv(chSurv[k+1]),
      .fwdCntE(chCntE[k+1]),
      .fwdCntG(chCntG[k+1])
    );
  end

  logic unusedTail;
  assign unusedTail = ^{chKey[NUM_SEGS], strb.stageLoad};

  logic             anyHit;
  logic [IDX_W-1:0] winIdx;

  segTcamPrioEnc #(.N(ENTRIES)) uPrio (
    .req(chSurv[NUM_SEGS]),
    .any(anyHit),
    .idx(winIdx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resHit  <= 1'b0;
      resIdx  <= '0;
      resCntE <= '0;
      resCntG <= '0;
    end else if (strb.resLoad) begin
      resHit  <= anyHit;
      resIdx  <= winIdx;
      resCntE <= chCntE[NUM_SEGS];
      resCntG <= chCntG[NUM_SEGS];
    end
  end
endmodule

// File: rtl/segTcam.sv
module segTcam import segTcamPkg::*; #(
  parameter int ENTRIES    = 64,
  parameter int GROUP_SIZE = 8,
  parameter int SEG0_W     = 8,
  parameter int SEGN_W     = 34,
  parameter int NUM_SEGS   = 5,
  localparam int WORD_W    = SEG0_W + (NUM_SEGS - 1) * SEGN_W,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int GROUPS    = ENTRIES / GROUP_SIZE,
  localparam int CNT_W     = $clog2(ENTRIES + 1),
  localparam int GCNT_W    = $clog2(GROUPS + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [IDX_W-1:0]           wrIdx,
  input  logic [WORD_W-1:0]          wrValue,
  input  logic [WORD_W-1:0]          wrDontCare,
  input  logic                       srchValid,
  input  logic [WORD_W-1:0]          srchKey,
  output logic                       resValid,
  output logic                       matchValid,
  output logic [IDX_W-1:0]           matchIdx,
  output logic [NUM_SEGS*CNT_W-1:0]  actEntries,
  output logic [NUM_SEGS*GCNT_W-1:0] actGroups
);
  camStrobes_t strb;
  logic        resHit;

  segTcamCtrl #(.NUM_SEGS(NUM_SEGS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .srchValid(srchValid),
    .strb     (strb),
    .resValid (resValid)
  );

  segTcamDatapath #(
    .ENTRIES   (ENTRIES),
    .GROUP_SIZE(GROUP_SIZE),
    .SEG0_W    (SEG0_W),
    .SEGN_W    (SEGN_W),
    .NUM_SEGS  (NUM_SEGS)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrIdx     (wrIdx),
    .wrValue   (wrValue),
    .wrDontCare(wrDontCare),
    .srchKey   (srchKey),
    .resHit    (resHit),
    .resIdx    (matchIdx),
    .resCntE   (actEntries),
    .resCntG   (actGroups)
  );

  assign matchValid = resValid & resHit;
endmodule

// File: rtl/segTcamChecker.sv
module segTcamChecker #(
  parameter int ENTRIES    = 64,
  parameter int GROUP_SIZE = 8,
  parameter int NUM_SEGS   = 5,
  localparam int GROUPS    = ENTRIES / GROUP_SIZE,
  localparam int CNT_W     = $clog2(ENTRIES + 1),
  localparam int GCNT_W    = $clog2(GROUPS + 1)
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       srchValid,
  input logic                       resValid,
  input logic                       matchValid,
  input logic [NUM_SEGS*CNT_W-1:0]  actEntries,
  input logic [NUM_SEGS*GCNT_W-1:0] actGroups
);
  logic [NUM_SEGS:0] seenKey;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenKey <= '0;
    else       seenKey <= {seenKey[NUM_SEGS-1:0], srchValid};
  end

  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    resValid == seenKey[NUM_SEGS]);

  p_hit_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |-> resValid);

  p_hit_has_survivor_r4: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |-> (actEntries[(NUM_SEGS-1)*CNT_W +: CNT_W] != '0));

  for (genvar k = 0; k < NUM_SEGS - 1; k++) begin : gMono
    p_shrink_r7: assert property (@(posedge clk) disable iff (!rstN)
      resValid |-> (actEntries[(k+1)*CNT_W +: CNT_W] <= actEntries[k*CNT_W +: CNT_W]));
  end

  for (genvar k = 0; k < NUM_SEGS; k++) begin : gBound
    p_group_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
      resValid |-> ((int'(actGroups[k*GCNT_W +: GCNT_W]) <= int'(actEntries[k*CNT_W +: CNT_W])) &&
                    (int'(actEntries[k*CNT_W +: CNT_W]) <= GROUP_SIZE * int'(actGroups[k*GCNT_W +: GCNT_W]))));
  end
endmodule

bind segTcam segTcamChecker #(
  .ENTRIES   (ENTRIES),
  .GROUP_SIZE(GROUP_SIZE),
  .NUM_SEGS  (NUM_SEGS)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .srchValid (srchValid),
  .resValid  (resValid),
  .matchValid(matchValid),
  .actEntries(actEntries),
  .actGroups (actGroups)
);

// File: tb/tb_segTcam.sv
module tb_segTcam;
  localparam int ENTRIES = 64, GROUP_SIZE = 8, SEG0_W = 8, SEGN_W = 34, NUM_SEGS = 5;
  localparam int WORD_W = 144, IDX_W = 6, GROUPS = 8, CNT_W = 7, GCNT_W = 4;
  localparam int MAXQ = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [IDX_W-1:0] wrIdx = '0;
  logic [WORD_W-1:0] wrValue = '0, wrDontCare = '0, srchKey = '0;
  logic srchValid = 1'b0;
  logic resValid, matchValid;
  logic [IDX_W-1:0] matchIdx;
  logic [NUM_SEGS*CNT_W-1:0] actEntries;
  logic [NUM_SEGS*GCNT_W-1:0] actGroups;

  segTcam dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrValue(wrValue),
    .wrDontCare(wrDontCare), .srchValid(srchValid), .srchKey(srchKey),
    .resValid(resValid), .matchValid(matchValid), .matchIdx(matchIdx),
    .actEntries(actEntries), .actGroups(actGroups)
  );

  always #5 clk = ~clk;

  // Reference table: single-cycle masked compare.
  logic [WORD_W-1:0] refVal [ENTRIES];
  logic [WORD_W-1:0] refDc  [ENTRIES];
  bit                refOk  [ENTRIES];

  bit                        expHit [MAXQ];
  int                        expIdx [MAXQ];
  logic [NUM_SEGS*CNT_W-1:0]  expE  [MAXQ];
  logic [NUM_SEGS*GCNT_W-1:0] expG  [MAXQ];

  int checks = 0, fails = 0, issued = 0, seen = 0;
  bit done = 1'b0;
  bit [NUM_SEGS:0] keyPipe = '0;

  function automatic logic [WORD_W-1:0] segMaskOf(int k);
    logic [WORD_W-1:0] m;
    int lo = WORD_W - SEG0_W - k * SEGN_W;
    int w  = (k == 0) ? SEG0_W : SEGN_W;
    for (int b = 0; b < WORD_W; b++) m[b] = (b >= lo) && (b < lo + w);
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] mkWord(int e);
    logic [7:0]  s0 = 8'(e % 4) ^ 8'hA5;
    logic [33:0] s1 = 34'(e % 8) ^ 34'h2_1234_5678;
    logic [33:0] s2 = 34'(e % 16) ^ 34'h1_ABCD_0123;
    logic [33:0] s3 = 34'(e % 32) ^ 34'h3_0F0F_0F0F;
    logic [33:0] s4 = 34'(e) ^ 34'h0_5555_AAAA;
    return {s0, s1, s2, s3, s4};
  endfunction

  function automatic logic [WORD_W-1:0] mkDc(int e);
    if (e == 63) return segMaskOf(4);
    if (e == 40) return segMaskOf(0);
    if (e == 5)  return 144'h3;
    return '0;
  endfunction

  task automatic predict(input logic [WORD_W-1:0] key, input int slot);
    bit surv [ENTRIES];
    for (int e = 0; e < ENTRIES; e++) surv[e] = refOk[e];
    expE[slot] = '0;
    expG[slot] = '0;
    for (int k = 0; k < NUM_SEGS; k++) begin
      int ne = 0, ng = 0;
      for (int g = 0; g < GROUPS; g++) begin
        bit live = 0;
        for (int j = 0; j < GROUP_SIZE; j++) if (surv[g*GROUP_SIZE+j]) begin ne++; live = 1; end
        if (live) ng++;
      end
      expE[slot][k*CNT_W +: CNT_W] = CNT_W'(ne);
      expG[slot][k*GCNT_W +: GCNT_W] = GCNT_W'(ng);
      for (int e = 0; e < ENTRIES; e++)
        if (((refVal[e] ^ key) & ~refDc[e] & segMaskOf(k)) != '0) surv[e] = 0;
    end
    expHit[slot] = 0;
    expIdx[slot] = 0;
    for (int e = ENTRIES - 1; e >= 0; e--) if (surv[e]) begin expHit[slot] = 1; expIdx[slot] = e; end
  endtask

  always @(posedge clk) keyPipe <= {keyPipe[NUM_SEGS-1:0], srchValid};

  // Monitor: samples on the falling edge, half a cycle after outputs move.
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (resValid !== keyPipe[NUM_SEGS]) begin
        fails++;
        $display("FAIL R3 result strobe: actual %0b expected %0b", resValid, keyPipe[NUM_SEGS]);
      end
      if (resValid === 1'b1 && seen < MAXQ) begin
        // R4 winner/hit, R5 entry counts, R6 group counts against the reference
        checks++;
        if (matchValid !== expHit[seen] || (expHit[seen] && matchIdx !== IDX_W'(expIdx[seen])) ||
            actEntries !== expE[seen] || actGroups !== expG[seen]) begin
          fails++;
          $display("FAIL R4/R5/R6 key %0d: actual hit %0b idx %0d ent %h grp %h, expected hit %0b idx %0d ent %h grp %h",
                   seen, matchValid, matchIdx, actEntries, actGroups,
                   expHit[seen], expIdx[seen], expE[seen], expG[seen]);
        end
        // R7 stage activity never grows
        checks++;
        for (int k = 0; k + 1 < NUM_SEGS; k++)
          if (actEntries[(k+1)*CNT_W +: CNT_W] > actEntries[k*CNT_W +: CNT_W]) begin
            fails++;
            $display("FAIL R7 stage %0d count: actual %0d expected at most %0d", k + 1,
                     actEntries[(k+1)*CNT_W +: CNT_W], actEntries[k*CNT_W +: CNT_W]);
            break;
          end
        seen++;
      end
    end
  end

  task automatic doWrite(input int idx, input logic [WORD_W-1:0] v, input logic [WORD_W-1:0] dc);
    @(negedge clk);
    srchValid = 1'b0;
    wrEn = 1'b1; wrIdx = IDX_W'(idx); wrValue = v; wrDontCare = dc;
    refVal[idx] = v; refDc[idx] = dc; refOk[idx] = 1;
  endtask

  task automatic issue(input logic [WORD_W-1:0] key);
    @(negedge clk);
    wrEn = 1'b0;
    srchValid = 1'b1; srchKey = key;
    predict(key, issued);
    issued++;
  endtask

  task automatic drain(input int n);
    @(negedge clk);
    wrEn = 1'b0; srchValid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  function automatic logic [WORD_W-1:0] flipIn(int e, int s);
    int lo = WORD_W - SEG0_W - s * SEGN_W;
    int w  = (s == 0) ? SEG0_W : SEGN_W;
    return mkWord(e) ^ (144'd1 << (lo + (e % w)));
  endfunction

  initial begin
    for (int e = 0; e < ENTRIES; e++) begin refVal[e] = '0; refDc[e] = '0; refOk[e] = 0; end
    // R8 reset state
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (resValid !== 1'b0 || matchValid !== 1'b0) begin
        fails++;
        $display("FAIL R8 reset outputs: actual %0b/%0b expected 0/0", resValid, matchValid);
      end
    end
    rstN = 1'b1;
    // R2: nothing written yet, so even an all-matching probe misses
    issue(mkWord(0));
    drain(8);
    for (int e = 0; e < ENTRIES; e++) doWrite(e, mkWord(e), mkDc(e));
    drain(2);
    // R9 back-to-back keys, every stored word
    for (int e = 0; e < ENTRIES; e++) issue(mkWord(e));
    // R5: single-bit corruption in each segment stops at that stage
    foreach (expHit[i]) if (i < 5) begin
      int picks [5] = '{0, 17, 31, 63, 22};
      for (int s = 0; s < NUM_SEGS; s++) issue(flipIn(picks[i], s));
    end
    // R1 wildcard entries: 5 ignores two low bits, 63 ignores the last segment, 40 the first
    for (int v = 0; v < 4; v++) issue((mkWord(5) & ~144'h3) | 144'(v));
    for (int v = 0; v < 4; v++) issue((mkWord(63) & ~segMaskOf(4)) | (144'($urandom) & segMaskOf(4)));
    issue((mkWord(8) & ~segMaskOf(0)) | (144'h5A << (WORD_W - SEG0_W)));
    issue((mkWord(40) & ~segMaskOf(0)) | (144'h3C << (WORD_W - SEG0_W)));
    // partly random keys
    for (int n = 0; n < 50; n++) begin
      logic [WORD_W-1:0] rnd = {$urandom, $urandom, $urandom, $urandom, $urandom};
      int s = $urandom % NUM_SEGS;
      logic [WORD_W-1:0] base = mkWord($urandom % ENTRIES);
      issue((base & ~segMaskOf(s)) | (rnd & segMaskOf(s)));
    end
    // sparse issue so idle cycles show no strobe (R3)
    for (int n = 0; n < 4; n++) begin issue(mkWord(n * 9)); drain(2); end
    drain(8);
    // R2 rewrite: entry 10 takes entry 50's word, old word of 10 is gone
    doWrite(10, mkWord(50), '0);
    drain(2);
    issue(mkWord(50));
    issue(mkWord(10));
    drain(12);
    checks++;
    if (seen != issued) begin
      fails++;
      $display("FAIL R3 result count: actual %0d expected %0d", seen, issued);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule